// File: doc/BRIEF.md
# SPI Master Burst Serializer

This engine empties a queue of 32-bit transmit words onto an SPI link as the bus master. It shifts each word out one byte at a time, most significant bit first. It gathers the bytes returned by the slave into receive words and hands them to a receive queue. Both queues sit outside the block. The transmit queue shows its head word on `tx_data` and advances on `tx_pop`. The receive queue accepts `rx_data` on `rx_push`.

The number of bits in a burst comes from a length field, rounded up to whole bytes. The burst counter lives across runs. A burst may therefore span several start strobes, and a burst whose length is not a multiple of 32 places its odd remainder in the first word.

The mode is chosen from the channel configuration inputs. In single-burst mode a run stops when a burst ends. In multi-burst mode the engine keeps opening new bursts until the transmit queue runs dry, and it raises an exchange-set pulse at the start of each burst. Status is reported as single-cycle pulses that a register block outside this engine turns into sticky flags.

Top module: `spi_burst_engine`

## Requirements
- R1: A `start` pulse while idle raises `busy` on the next clock edge. `busy` stays high until the cycle after the `set_done` pulse. A `start` that arrives while `busy` is high is ignored and does not trigger a second run.
- R2: The burst length in bits is `burst_field + 1` rounded up to the next multiple of 8 (for example field 11 gives 16 bits, field 39 gives 40 bits).
- R3: For each word taken from the transmit queue, the engine sends the burst counter modulo 32 bits, or 32 bits when that remainder is 0. These are the low-order bits of the word. They go out as bytes starting with the highest byte that is used, each byte MSB first on `mosi`.
- R4: Each received byte enters the receive word from the low end, so the first byte ends up highest. Bits above the bytes received are zero. The word is presented on `rx_data` with a one-cycle `rx_push`.
- R5: When `rx_full` is high at the end of a word, the word is dropped. `set_ovf` pulses for one cycle and `rx_push` stays low.
- R6: The burst counter is reloaded from the burst length only when a word is fetched with the counter at zero. It drops by 8 per byte and keeps its value between runs, so an unfinished burst resumes on the next start.
- R7: Multi-burst mode holds only when all three of these are true: bit `chan_sel` of `chan_master` is 1, `imm_start` is 0, and bit `chan_sel` of `ss_wave` is 1. In this mode every burst reload pulses `xch_set`, and no other case pulses it.
- R8: Outside multi-burst mode, the end of a burst ends the run with a `set_done` pulse even if transmit words remain. In that case `xch_clr` stays low.
- R9: When the transmit queue is empty at the end of a run, `set_done` and `xch_clr` pulse together. A start with an empty queue ends the run at once and shifts no bits.
- R10: SPI mode 0 is used. `sclk` is low whenever the engine is idle. Each high and low phase lasts `CLK_DIV/2` clock cycles. `mosi` changes only as `sclk` falls. `miso` is sampled as `sclk` rises.
- R11: After reset `busy`, `sclk`, `mosi` and all pulse outputs are low, and the burst counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (ignored while busy) |
| burst_field | input | LEN_W | Burst length minus one, in bits |
| chan_sel | input | SEL_W | Selected channel |
| chan_master | input | NCH | Per-channel master-mode bits |
| ss_wave | input | NCH | Per-channel multi-burst select bits |
| imm_start | input | 1 | Immediate-start mode (disables multi-burst) |
| tx_empty | input | 1 | Transmit queue is empty |
| tx_data | input | 32 | Head word of the transmit queue |
| tx_pop | output | 1 | Take the head transmit word |
| rx_full | input | 1 | Receive queue is full |
| rx_push | output | 1 | Write `rx_data` into the receive queue |
| rx_data | output | 32 | Assembled receive word |
| set_done | output | 1 | Transfer-complete pulse |
| set_ovf | output | 1 | Receive-overflow pulse |
| xch_set | output | 1 | Exchange-bit set pulse |
| xch_clr | output | 1 | Exchange-bit clear pulse |
| busy | output | 1 | A run is in progress |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A wrong burst counter first shows on `mosi` as the wrong number of bytes for a word, or as bytes taken from the wrong end of it, within one word time. If the counter fails to carry over, the damage appears only on the following start strobe. That is why the bench checks runs back to back without a reset in between. A wrong mode decision shows within one burst: the engine either stops early with words still queued, or runs on past the point where it should stop, and the `xch_set` pulse count differs. A wrong receive path shows at the first `rx_push`, as a byte out of place in `rx_data` or as a push into a full queue.

// File: rtl/spi_burst_engine.sv
module spi_burst_engine #(
  parameter int LEN_W   = 12,
  parameter int NCH     = 4,
  parameter int SEL_W   = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int CLK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] burst_field,
  input  logic [SEL_W-1:0] chan_sel,
  input  logic [NCH-1:0]   chan_master,
  input  logic [NCH-1:0]   ss_wave,
  input  logic             imm_start,
  input  logic             tx_empty,
  input  logic [31:0]      tx_data,
  output logic             tx_pop,
  input  logic             rx_full,
  output logic             rx_push,
  output logic [31:0]      rx_data,
  output logic             set_done,
  output logic             set_ovf,
  output logic             xch_set,
  output logic             xch_clr,
  output logic             busy,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);

  localparam int CNT_W = LEN_W + 1;
  localparam int HALF  = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;
  localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_SHIFT, S_WEND, S_FIN} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      word, rx_word;
  logic [7:0]       tx_sh, rx_sh;
  logic [2:0]       bit_idx;
  logic [1:0]       byte_idx;
  logic [DIV_W-1:0] div;
  logic             sclk_q;

  function automatic logic [7:0] pick(input logic [31:0] w, input logic [1:0] i);
    return w[{i, 3'b000} +: 8];
  endfunction

  logic             multi;
  logic [CNT_W-1:0] blen, cnt_eff;
  logic [1:0]       first_idx;
  logic             tick;

  assign multi     = chan_master[chan_sel] & ~imm_start & ss_wave[chan_sel];
  assign blen      = (CNT_W'(burst_field) + CNT_W'(8)) & ~CNT_W'(7);
  assign cnt_eff   = (cnt == '0) ? blen : cnt;
  assign first_idx = (cnt_eff[4:3] == 2'd0) ? 2'd3 : cnt_eff[4:3] - 2'd1;
  assign tick      = (div == DIV_W'(HALF - 1));

  assign busy     = (st != S_IDLE);
  assign tx_pop   = (st == S_FETCH) & ~tx_empty;
  assign xch_set  = tx_pop & (cnt == '0) & multi;
  assign rx_push  = (st == S_WEND) & ~rx_full;
  assign set_ovf  = (st == S_WEND) & rx_full;
  assign set_done = (st == S_FIN);
  assign xch_clr  = (st == S_FIN) & tx_empty;
  assign rx_data  = rx_word;
  assign sclk     = sclk_q;
  assign mosi     = (st == S_SHIFT) & tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      word     <= '0;
      rx_word  <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      bit_idx  <= '0;
      byte_idx <= '0;
      div      <= '0;
      sclk_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) st <= S_FETCH;
        S_FETCH: begin
          if (tx_empty) st <= S_FIN;
          else begin
            cnt      <= cnt_eff;
            word     <= tx_data;
            byte_idx <= first_idx;
            tx_sh    <= pick(tx_data, first_idx);
            rx_word  <= '0;
            bit_idx  <= '0;
            div      <= '0;
            sclk_q   <= 1'b0;
            st       <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (!tick) div <= div + DIV_W'(1);
          else begin
            div <= '0;
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              rx_sh  <= {rx_sh[6:0], miso};
            end else begin
              sclk_q <= 1'b0;
              if (bit_idx == 3'd7) begin
                bit_idx <= '0;
                cnt     <= cnt - CNT_W'(8);
                rx_word <= {rx_word[23:0], rx_sh};
                if (byte_idx == 2'd0) st <= S_WEND;
                else begin
                  byte_idx <= byte_idx - 2'd1;
                  tx_sh    <= pick(word, byte_idx - 2'd1);
                end
              end else begin
                bit_idx <= bit_idx + 3'd1;
                tx_sh   <= {tx_sh[6:0], 1'b0};
              end
            end
          end
        end
        S_WEND: st <= ((cnt == '0) && !multi) ? S_FIN : S_FETCH;
        S_FIN:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);
  a_r5_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);
  a_r5_push_or_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_push, set_ovf}));
  a_r9_clr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    xch_clr |-> set_done);
  a_r8_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |=> !busy);
  a_r1_busy_falls_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(set_done));
  a_r10_idle_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  a_r10_mosi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

endmodule

// File: tb/sim_spi_burst_engine.sv
`timescale 1ns/1ps
module sim_spi_burst_engine;
  localparam int LEN_W = 12, NCH = 4, SEL_W = 2, CLK_DIV = 4, HALF = CLK_DIV / 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [LEN_W-1:0] burst_field = '0;
  logic [SEL_W-1:0] chan_sel = '0;
  logic [NCH-1:0] chan_master = 4'b0001, ss_wave = '0;
  logic imm_start = 1'b0;
  logic tx_empty, tx_pop, rx_full, rx_push, set_done, set_ovf, xch_set, xch_clr;
  logic busy, sclk, mosi, miso;
  logic [31:0] tx_data, rx_data;

  always #2 clk = ~clk;

  spi_burst_engine #(.LEN_W(LEN_W), .NCH(NCH), .SEL_W(SEL_W), .CLK_DIV(CLK_DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .burst_field(burst_field),
    .chan_sel(chan_sel), .chan_master(chan_master), .ss_wave(ss_wave),
    .imm_start(imm_start), .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data), .set_done(set_done),
    .set_ovf(set_ovf), .xch_set(xch_set), .xch_clr(xch_clr), .busy(busy),
    .sclk(sclk), .mosi(mosi), .miso(miso));

  int nchk = 0, nerr = 0;
  logic [31:0] txq [0:31];
  int tx_wr = 0, tx_rd = 0;
  logic [31:0] rxq [0:63];
  int rxn = 0, rxcap = 64;
  int n_done = 0, n_clr = 0, n_xset = 0, n_ovf = 0;
  logic [7:0] mo [0:255];
  int nmo = 0, nb = 0, k = 0;
  logic [7:0] cap = '0, sreg;
  int hi_len = 0, r10_bad = 0;

  function automatic logic [7:0] pat(input int j);
    return 8'h3C + 8'(j * 23);
  endfunction

  assign tx_empty = (tx_rd == tx_wr);
  assign tx_data  = txq[tx_rd[4:0]];
  assign rx_full  = (rxn >= rxcap);
  assign miso     = sreg[7];

  always @(posedge clk) begin
    if (tx_pop) tx_rd <= tx_rd + 1;
    if (rx_push) begin rxq[rxn[5:0]] <= rx_data; rxn <= rxn + 1; end
  end

  always @(negedge clk) begin
    if (set_done) n_done++;
    if (xch_clr) n_clr++;
    if (xch_set) n_xset++;
    if (set_ovf) n_ovf++;
    if (sclk) hi_len++;
    else begin
      if (hi_len != 0 && hi_len != HALF) r10_bad++;
      hi_len = 0;
      if (!busy && rst_n && mosi) r10_bad++;
    end
  end

  initial sreg = pat(0);
  always @(posedge sclk) begin
    cap = {cap[6:0], mosi};
    nb++;
    if (nb == 8) begin mo[nmo[7:0]] = cap; nmo++; nb = 0; end
  end
  always @(negedge sclk) begin
    if (nb == 0) begin k++; sreg = pat(k); end
    else sreg = {sreg[6:0], 1'b0};
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    txq[tx_wr[4:0]] = w;
    tx_wr++;
  endtask

  task automatic run_once();
    int t;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] rxw(input int b, input int n);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) v = {v[23:0], pat(b + i)};
    return v;
  endfunction

  task automatic t_reset();
    chk("R11 busy", busy, 0);
    chk("R11 sclk", sclk, 0);
    chk("R11 mosi", mosi, 0);
    chk("R11 pulses", {tx_pop, rx_push, set_done, set_ovf, xch_set, xch_clr}, 0);
  endtask

  task automatic t_full_word();
    int b = nmo, r = rxn, d = n_done, c = n_clr;
    burst_field = 31; ss_wave = 0; imm_start = 0;
    push(32'h12345678);
    run_once();
    chk("R3 byte count", nmo - b, 4);
    chk("R3 msb-first bytes", {mo[b[7:0]], mo[8'(b+1)], mo[8'(b+2)], mo[8'(b+3)]}, 32'h12345678);
    chk("R4 rx word", rxq[r[5:0]], rxw(b, 4));
    chk("R9 done", n_done - d, 1);
    chk("R9 xch clr", n_clr - c, 1);
  endtask

  task automatic t_round_up();
    int b = nmo, r = rxn;
    burst_field = 11;
    push(32'hAABBCCDD);
    run_once();
    chk("R2 16-bit burst bytes", nmo - b, 2);
    chk("R3 low bytes sent", {mo[b[7:0]], mo[8'(b+1)]}, 16'hCCDD);
    chk("R4 rx zero upper", rxq[r[5:0]], rxw(b, 2));
  endtask

  task automatic t_partial_and_persist();
    int b = nmo, r = rxn, d = n_done, c = n_clr;
    burst_field = 39;
    push(32'hA1B2C3D4); push(32'h11223344); push(32'h55667788);
    run_once();
    chk("R3 partial lead byte", mo[b[7:0]], 8'hD4);
    chk("R8 stop after burst bytes", nmo - b, 5);
    chk("R8 words left", tx_wr - tx_rd, 1);
    chk("R8 done no clr", {n_done - d, n_clr - c}, {32'd1, 32'd0});
    chk("R4 partial rx", rxq[r[5:0]], rxw(b, 1));
    b = nmo;
    run_once();
    chk("R6 reload 40 -> 8 bits", nmo - b, 1);
    chk("R6 byte", mo[b[7:0]], 8'h88);
    chk("R9 clr on empty", n_clr - c, 1);
    b = nmo;
    push(32'hCAFEF00D);
    run_once();
    chk("R6 resumed remainder 32 bits", nmo - b, 4);
    chk("R6 resumed bytes", {mo[b[7:0]], mo[8'(b+1)], mo[8'(b+2)], mo[8'(b+3)]}, 32'hCAFEF00D);
  endtask

  task automatic t_multi();
    int b = nmo, x = n_xset, d = n_done, c = n_clr, r = rxn;
    burst_field = 7; ss_wave = 4'b0001; imm_start = 0;
    push(32'h01); push(32'h02); push(32'h03);
    run_once();
    chk("R7 all bytes", nmo - b, 3);
    chk("R7 xch_set per burst", n_xset - x, 3);
    chk("R7 single done+clr", {n_done - d, n_clr - c}, {32'd1, 32'd1});
    chk("R7 rx words", rxn - r, 3);
  endtask

  task automatic t_multi_other_channel();
    int b = nmo, x = n_xset;
    chan_sel = 2; chan_master = 4'b0100; ss_wave = 4'b0100;
    push(32'h5A); push(32'hA5);
    run_once();
    chk("R7 selected channel multi", {nmo - b, n_xset - x}, {32'd2, 32'd2});
    chan_sel = 0; chan_master = 4'b0001;
  endtask

  task automatic t_not_multi_imm();
    int b = nmo, x = n_xset, c = n_clr;
    ss_wave = 4'b0001; imm_start = 1;
    push(32'h77); push(32'h66);
    run_once();
    chk("R7 imm blocks multi", {nmo - b, n_xset - x, n_clr - c}, {32'd1, 32'd0, 32'd0});
    run_once();
    chk("R8 rest on next start", mo[8'(nmo - 1)], 8'h66);
    imm_start = 0; ss_wave = 0;
  endtask

  task automatic t_overflow();
    int r = rxn, o = n_ovf;
    burst_field = 7; ss_wave = 4'b0001;
    rxcap = rxn + 1;
    push(32'h10); push(32'h20);
    run_once();
    chk("R5 one push", rxn - r, 1);
    chk("R5 ovf pulse", n_ovf - o, 1);
    rxn = 0; rxcap = 64; ss_wave = 0;
  endtask

  task automatic t_start_busy();
    int d = n_done, b = nmo;
    burst_field = 31;
    push(32'hDEADBEEF);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R1 busy next cycle", busy, 1);
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
    chk("R1 start while busy ignored", {n_done - d, 31'(busy)}, {32'd1, 31'd0});
    chk("R1 one word", nmo - b, 4);
  endtask

  task automatic t_empty_start();
    int d = n_done, c = n_clr, b = nmo;
    run_once();
    chk("R9 empty start done/clr/no bits", {n_done - d, n_clr - c, nmo - b}, {32'd1, 32'd1, 32'd0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_full_word();
    t_round_up();
    t_partial_and_persist();
    t_multi();
    t_multi_other_channel();
    t_not_multi_imm();
    t_overflow();
    t_start_busy();
    t_empty_start();
    chk("R10 sclk phase and idle", r10_bad, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule